// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is the device-side end of a three-wire configuration link. A host frames each transfer with an active-low select strobe, clocks bits with a serial clock, and uses one shared data line for both directions. Each transfer is 14 bits long: a direction flag, a 4-bit register address and a 9-bit payload. Writes update one of ten internal registers. Reads send the addressed register back on the same line. The pad-level tri-state is built outside the block, so the line is brought out as separate input, output and output-enable signals.

The registers are one mode/configuration word, one channel-sequencing word, four per-channel gain codes and four per-channel offset words. Their fields go straight to the signal chain as decoded control signals. The offset words are stored as written (sign and magnitude) but are delivered downstream as two's complement. The three link inputs are brought into the system clock domain by two-flop synchronisers, and all serial activity is decoded from edges seen in that domain.

Top module: `serial_cfg_slave`

## Requirements
- R1: After reset every register is zero except config bit D0, which is 1. So `cfg_awake`=1, all other exported fields are 0, `sdio_oe`=0, and a read of address 0 returns 0x001.
- R2: A frame is the bits sampled on rising `sclk` while `sload_n` is low. The order is the direction bit (0 = write), then A3..A0, then D8..D0, most significant first. A write takes effect on the 14th rising edge.
- R3: The address map is 0 = config, 1 = channel sequencing, 2..5 = gain A..D, and 6..9 = offset A..D. Every register reads back the value it holds.
- R4: Config bits map as D5 → `cfg_ext_ref`, D4 → `cfg_single_byte`, D3 → `cfg_sha_mode`, D2 → `cfg_range_hi`, D1 → `cfg_slow` and D0 → `cfg_awake`. D8..D6 are discarded and read back as 0.
- R5: Sequencing bit D4 drives `mux_reverse`. D3..D0 drive `mux_sel[3:0]`, with bit 3 = channel A and bit 0 = channel D. D8..D5 are discarded and read back as 0.
- R6: Each gain register keeps D5..D0 as an unsigned code on `gain_codes[6c+5:6c]` (c=0 is A). D8..D6 are discarded.
- R7: Each offset register keeps D8 (sign) and D7..D0 (magnitude). It is exported on `offset_twos[9c+8:9c]` as the 9-bit two's complement of ±magnitude, so a negative zero (0x100) exports 0. Read-back returns the stored sign-magnitude word.
- R8: A write to addresses 10..15 changes nothing, and a read from them returns 0.
- R9: With the direction bit at 1, the block drives D8 after the falling `sclk` that follows A0. It drives one further bit after each later falling edge, down to D0. `sdio_oe` is high from the first driven bit until `sload_n` returns high.
- R10: During a write frame `sdio_oe` stays low.
- R11: A frame ended by `sload_n` before its 14th bit writes nothing. Rising edges after the 14th bit are ignored, so the first 14 bits decide the write.
- R12: Clearing config D0 (power-down) leaves every other register's content, output and read-back unchanged.
- R13: Each link input passes through two flops and one edge flop. An exported field, `sdio_out` or `sdio_oe` therefore changes on the third `clk` rising edge after the input change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sload_n | input | 1 | Frame strobe, active low |
| sclk | input | 1 | Serial bit clock |
| sdio_in | input | 1 | Serial data from the line |
| sdio_out | output | 1 | Serial read data to the line |
| sdio_oe | output | 1 | Line driver enable for read data |
| cfg_ext_ref | output | 1 | External reference select |
| cfg_single_byte | output | 1 | Single-byte output mode |
| cfg_sha_mode | output | 1 | 1 = SHA sampling, 0 = CDS sampling |
| cfg_range_hi | output | 1 | 1 = 3 V range, 0 = 1.5 V range |
| cfg_slow | output | 1 | Reduced-speed mode |
| cfg_awake | output | 1 | 0 = power-down |
| mux_reverse | output | 1 | Reverse channel sequencing order |
| mux_sel | output | 4 | Single-channel select, bit 3 = A |
| gain_codes | output | 24 | Four 6-bit gain codes, A in the low bits |
| offset_twos | output | 36 | Four 9-bit two's complement offsets, A in the low bits |

## Verification
Every result of the block is due on the third `clk` rising edge after the link input that causes it. Register fields move three edges after the 14th rising `sclk`, read bits three edges after each falling `sclk`, and the driver enable drops three edges after `sload_n` rises. The bench drives inputs on falling `clk` edges and waits exactly three rising edges before it updates its behavioural model. It then compares every exported field, the enable and the driven bit against that model on every falling `clk` edge, so an output that is one cycle early or late is a miscompare. Serial clock phases last eight system clocks, which gives read bits a stable window in which the bench assembles each read word and checks it against the model.

// File: rtl/cfg_slave_pkg.sv
`timescale 1ns/1ps
package cfg_slave_pkg;
  localparam int CFG_ADDR_W  = 4;
  localparam int CFG_DATA_W  = 9;
  localparam int CFG_BITS    = 6;
  localparam int ADDR_CONFIG = 0;
  localparam int ADDR_MUX    = 1;
  localparam int ADDR_GAIN0  = 2;

  typedef struct packed {
    logic ext_ref;
    logic single_byte;
    logic sha_mode;
    logic range_hi;
    logic slow;
    logic awake;
  } cfg_fields_t;

  localparam logic [CFG_BITS-1:0] CFG_RESET = 6'b000001;
endpackage

// File: rtl/serial_sync.sv
`timescale 1ns/1ps
module serial_sync #(
  parameter int             W       = 3,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/serial_frame.sv
`timescale 1ns/1ps
module serial_frame
  import cfg_slave_pkg::*;
#(
  parameter int ADDR_W = CFG_ADDR_W,
  parameter int DATA_W = CFG_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_en,
  output logic              frm_read
);
  localparam int FRAME_LEN = 1 + ADDR_W + DATA_W;
  localparam int HDR_LEN   = 1 + ADDR_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] ADDR_DONE = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] HDR_CNT   = CNT_W'(HDR_LEN);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(FRAME_LEN);

  logic                 sck_q;
  logic                 sck_rise, sck_fall;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [FRAME_LEN-2:0] shift_q, shift_d;
  logic [DATA_W-1:0]    rdsh_q, rdsh_d;
  logic                 read_q, read_d;
  logic                 sdo_q, sdo_d;
  logic                 en_q, en_d;

  assign sck_rise = sck & ~sck_q;
  assign sck_fall = ~sck & sck_q;

  // Address becomes complete with the current incoming bit
  assign rd_addr = {shift_q[ADDR_W-2:0], sdi};
  assign wr_addr = shift_q[DATA_W-1 +: ADDR_W];
  assign wr_data = {shift_q[DATA_W-2:0], sdi};
  assign wr_en   = ~sel_n & sck_rise & (cnt_q == LAST_CNT) & ~shift_q[FRAME_LEN-2];

  always_comb begin
    cnt_d   = cnt_q;
    shift_d = shift_q;
    rdsh_d  = rdsh_q;
    read_d  = read_q;
    sdo_d   = sdo_q;
    en_d    = en_q;
    if (sel_n) begin
      cnt_d  = '0;
      read_d = 1'b0;
      en_d   = 1'b0;
    end else begin
      if (sck_rise && (cnt_q != FULL_CNT)) begin
        shift_d = {shift_q[FRAME_LEN-3:0], sdi};
        cnt_d   = cnt_q + 1'b1;
        if (cnt_q == ADDR_DONE) begin
          read_d = shift_q[ADDR_W-1];
          rdsh_d = rd_word;
        end
      end
      if (sck_fall && read_q && (cnt_q >= HDR_CNT) && (cnt_q <= LAST_CNT)) begin
        sdo_d  = rdsh_q[DATA_W-1];
        rdsh_d = {rdsh_q[DATA_W-2:0], 1'b0};
        en_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      cnt_q   <= '0;
      shift_q <= '0;
      rdsh_q  <= '0;
      read_q  <= 1'b0;
      sdo_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      sck_q   <= sck;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      rdsh_q  <= rdsh_d;
      read_q  <= read_d;
      sdo_q   <= sdo_d;
      en_q    <= en_d;
    end
  end

  assign sdo      = sdo_q;
  assign sdo_en   = en_q;
  assign frm_read = read_q;
endmodule

// File: rtl/cfg_regbank.sv
`timescale 1ns/1ps
module cfg_regbank
  import cfg_slave_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int GAIN_W = 6,
  parameter int ADDR_W = CFG_ADDR_W,
  parameter int DATA_W = CFG_DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_word,
  output logic [CFG_BITS-1:0]      cfg_bits,
  output logic [NUM_CH:0]          mux_bits,
  output logic [NUM_CH*GAIN_W-1:0] gain_flat,
  output logic [NUM_CH*DATA_W-1:0] ofs_flat
);
  localparam int MUX_W    = NUM_CH + 1;
  localparam int OFS_BASE = ADDR_GAIN0 + NUM_CH;
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(ADDR_CONFIG);
  localparam logic [ADDR_W-1:0] A_MUX = ADDR_W'(ADDR_MUX);

  logic [CFG_BITS-1:0] cfg_q, cfg_d;
  logic [MUX_W-1:0]    mux_q, mux_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en && (wr_addr == A_CFG)) cfg_d = wr_data[CFG_BITS-1:0];
    mux_d = mux_q;
    if (wr_en && (wr_addr == A_MUX)) mux_d = wr_data[MUX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      mux_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      mux_q <= mux_d;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_GAIN = ADDR_W'(ADDR_GAIN0 + c);
    localparam logic [ADDR_W-1:0] A_OFS  = ADDR_W'(OFS_BASE + c);
    logic [GAIN_W-1:0] gain_q, gain_d;
    logic [DATA_W-1:0] ofs_q, ofs_d;
    logic              gain_we, ofs_we;

    assign gain_we = wr_en && (wr_addr == A_GAIN);
    assign ofs_we  = wr_en && (wr_addr == A_OFS);

    always_comb begin
      gain_d = gain_q;
      if (gain_we) gain_d = wr_data[GAIN_W-1:0];
      ofs_d = ofs_q;
      if (ofs_we) ofs_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gain_q <= '0;
        ofs_q  <= '0;
      end else begin
        gain_q <= gain_d;
        ofs_q  <= ofs_d;
      end
    end

    assign gain_flat[c*GAIN_W +: GAIN_W] = gain_q;
    assign ofs_flat[c*DATA_W +: DATA_W]  = ofs_q;
  end

  always_comb begin
    rd_word = '0;
    if (rd_addr == A_CFG) rd_word = DATA_W'(cfg_q);
    if (rd_addr == A_MUX) rd_word = DATA_W'(mux_q);
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr == ADDR_W'(ADDR_GAIN0 + c)) rd_word = DATA_W'(gain_flat[c*GAIN_W +: GAIN_W]);
      if (rd_addr == ADDR_W'(OFS_BASE + c))   rd_word = ofs_flat[c*DATA_W +: DATA_W];
    end
  end

  assign cfg_bits = cfg_q;
  assign mux_bits = mux_q;
endmodule

// File: rtl/ofs_twos.sv
`timescale 1ns/1ps
module ofs_twos #(
  parameter int W = 9
) (
  input  logic [W-1:0] sm_in,
  output logic [W-1:0] tc_out
);
  logic [W-1:0] mag;

  assign mag    = {1'b0, sm_in[W-2:0]};
  assign tc_out = sm_in[W-1] ? (~mag + 1'b1) : mag;
endmodule

// File: rtl/serial_cfg_slave.sv
`timescale 1ns/1ps
module serial_cfg_slave
  import cfg_slave_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int GAIN_W = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sload_n,
  input  logic                         sclk,
  input  logic                         sdio_in,
  output logic                         sdio_out,
  output logic                         sdio_oe,
  output logic                         cfg_ext_ref,
  output logic                         cfg_single_byte,
  output logic                         cfg_sha_mode,
  output logic                         cfg_range_hi,
  output logic                         cfg_slow,
  output logic                         cfg_awake,
  output logic                         mux_reverse,
  output logic [NUM_CH-1:0]            mux_sel,
  output logic [NUM_CH*GAIN_W-1:0]     gain_codes,
  output logic [NUM_CH*CFG_DATA_W-1:0] offset_twos
);
  localparam int ADDR_W = CFG_ADDR_W;
  localparam int DATA_W = CFG_DATA_W;
  localparam int SNAP_W = CFG_BITS + NUM_CH + 1 + NUM_CH * (GAIN_W + DATA_W);

  logic                     sel_n_s, sck_s, sdi_s;
  logic [ADDR_W-1:0]        rd_addr, wr_addr;
  logic [DATA_W-1:0]        rd_word, wr_data;
  logic                     wr_en, frm_read;
  logic [CFG_BITS-1:0]      cfg_bits;
  logic [NUM_CH:0]          mux_bits;
  logic [NUM_CH*DATA_W-1:0] ofs_raw;
  logic [SNAP_W-1:0]        reg_snap;
  cfg_fields_t              cfg_f;

  serial_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sload_n, sclk, sdio_in}),
    .q     ({sel_n_s, sck_s, sdi_s})
  );

  serial_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n_s),
    .sck      (sck_s),
    .sdi      (sdi_s),
    .rd_word  (rd_word),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sdo      (sdio_out),
    .sdo_en   (sdio_oe),
    .frm_read (frm_read)
  );

  cfg_regbank #(.NUM_CH(NUM_CH), .GAIN_W(GAIN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_word   (rd_word),
    .cfg_bits  (cfg_bits),
    .mux_bits  (mux_bits),
    .gain_flat (gain_codes),
    .ofs_flat  (ofs_raw)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ofs
    ofs_twos #(.W(DATA_W)) u_conv (
      .sm_in  (ofs_raw[c*DATA_W +: DATA_W]),
      .tc_out (offset_twos[c*DATA_W +: DATA_W])
    );
  end

  assign cfg_f           = cfg_fields_t'(cfg_bits);
  assign cfg_ext_ref     = cfg_f.ext_ref;
  assign cfg_single_byte = cfg_f.single_byte;
  assign cfg_sha_mode    = cfg_f.sha_mode;
  assign cfg_range_hi    = cfg_f.range_hi;
  assign cfg_slow        = cfg_f.slow;
  assign cfg_awake       = cfg_f.awake;
  assign mux_reverse     = mux_bits[NUM_CH];
  assign mux_sel         = mux_bits[NUM_CH-1:0];
  assign reg_snap        = {cfg_bits, mux_bits, gain_codes, ofs_raw};
endmodule

// File: rtl/cfg_slave_chk.sv
`timescale 1ns/1ps
module cfg_slave_chk
  import cfg_slave_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 9,
  parameter int ADDR_W = 4,
  parameter int SNAP_W = 71
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sload_n,
  input logic                     sdio_oe,
  input logic                     frm_read,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic [SNAP_W-1:0]        reg_snap,
  input logic [NUM_CH*DATA_W-1:0] ofs_raw,
  input logic [NUM_CH*DATA_W-1:0] offset_twos
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(ADDR_GAIN0 + 2 * NUM_CH - 1);

  AST_WR_INSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(sload_n, 2)); // R2

  AST_UNUSED_ADDR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr > TOP_ADDR)) |=> $stable(reg_snap)); // R8

  AST_IDLE_REGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sload_n, 2) && $past(sload_n, 3)) |-> $stable(reg_snap)); // R11

  AST_OE_RELEASED_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sload_n) && $past(sload_n, 2) && $past(sload_n, 3)) |-> !sdio_oe); // R9

  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> frm_read); // R10

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sign
    AST_OFS_NEG_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (ofs_raw[c*DATA_W + DATA_W-1] && (|ofs_raw[c*DATA_W +: DATA_W-1]))
        |-> offset_twos[c*DATA_W + DATA_W-1]); // R7
    AST_OFS_POS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      !ofs_raw[c*DATA_W + DATA_W-1] |-> !offset_twos[c*DATA_W + DATA_W-1]); // R7
  end
endmodule

bind serial_cfg_slave cfg_slave_chk #(
  .NUM_CH (NUM_CH),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .SNAP_W (SNAP_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sload_n     (sload_n),
  .sdio_oe     (sdio_oe),
  .frm_read    (frm_read),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .reg_snap    (reg_snap),
  .ofs_raw     (ofs_raw),
  .offset_twos (offset_twos)
);

// File: tb/serial_cfg_slave_tb_top.sv
`timescale 1ns/1ps
module serial_cfg_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sload_n = 1'b1;
  logic sclk = 1'b0;
  logic sdio_in = 1'b0;
  logic sdio_out, sdio_oe;
  logic cfg_ext_ref, cfg_single_byte, cfg_sha_mode, cfg_range_hi, cfg_slow, cfg_awake;
  logic mux_reverse;
  logic [3:0]  mux_sel;
  logic [23:0] gain_codes;
  logic [35:0] offset_twos;

  int n_vec = 0;
  int n_bad = 0;
  bit run_cmp = 0;
  bit done = 0;

  // behavioural model state
  int m_cfg = 1;
  int m_mux = 0;
  int m_gain[4] = '{0, 0, 0, 0};
  int m_ofs[4]  = '{0, 0, 0, 0};
  bit e_oe = 0;
  bit e_out = 0;
  bit in_wr_frame = 0;
  bit oe_seen_wr = 0;

  always #2.5 clk = ~clk;

  serial_cfg_slave dut_i (
    .clk (clk), .rst_n (rst_n), .sload_n (sload_n), .sclk (sclk),
    .sdio_in (sdio_in), .sdio_out (sdio_out), .sdio_oe (sdio_oe),
    .cfg_ext_ref (cfg_ext_ref), .cfg_single_byte (cfg_single_byte),
    .cfg_sha_mode (cfg_sha_mode), .cfg_range_hi (cfg_range_hi),
    .cfg_slow (cfg_slow), .cfg_awake (cfg_awake),
    .mux_reverse (mux_reverse), .mux_sel (mux_sel),
    .gain_codes (gain_codes), .offset_twos (offset_twos)
  );

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_read(int a);
    case (a)
      0: return m_cfg;
      1: return m_mux;
      2, 3, 4, 5: return m_gain[a-2];
      6, 7, 8, 9: return m_ofs[a-6];
      default: return 0;
    endcase
  endfunction

  function automatic int ofs_expect(int v);
    int mag = v & 255;
    if ((v & 256) != 0) return (-mag) & 511;
    return mag;
  endfunction

  function automatic void model_write(int a, int d);
    case (a)
      0: m_cfg = d & 63;
      1: m_mux = d & 31;
      2, 3, 4, 5: m_gain[a-2] = d & 63;
      6, 7, 8, 9: m_ofs[a-6] = d & 511;
      default: ;
    endcase
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (run_cmp) begin
      check("R4 R13 config fields",
            int'({cfg_ext_ref, cfg_single_byte, cfg_sha_mode, cfg_range_hi, cfg_slow, cfg_awake}),
            m_cfg & 63);
      check("R5 R13 sequencing fields", int'({mux_reverse, mux_sel}), m_mux & 31);
      for (int c = 0; c < 4; c++) begin
        check("R6 R13 gain code", int'(gain_codes[c*6 +: 6]), m_gain[c] & 63);
        check("R7 R13 offset two's complement", int'(offset_twos[c*9 +: 9]), ofs_expect(m_ofs[c]));
      end
      check("R9 R10 R13 driver enable", int'(sdio_oe), int'(e_oe));
      if (e_oe) check("R9 R13 driven bit", int'(sdio_out), int'(e_out));
      if (in_wr_frame && sdio_oe) oe_seen_wr = 1;
    end
  end

  // one frame; nbits rising edges inside the strobe
  task automatic xfer(bit rw, int addr, int data, int nbits, output int rd_back);
    logic [15:0] fr;
    int exp_rd;
    fr = {rw, 4'(addr), 9'(data), 2'b01};
    exp_rd = model_read(addr);
    rd_back = 0;
    in_wr_frame = !rw;
    @(negedge clk);
    sload_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      sdio_in = (i < 16) ? fr[15-i] : 1'b0;
      if (rw && i >= 5 && i <= 13) begin
        repeat (3) @(posedge clk);
        e_out = ((exp_rd >> (13 - i)) & 1) != 0;
        e_oe = 1;
      end
      repeat (7) @(negedge clk);
      if (rw && i >= 5 && i <= 13) rd_back = (rd_back << 1) | int'(sdio_out);
      sclk = 1'b1;
      if (!rw && i == 13) begin
        repeat (3) @(posedge clk);
        model_write(addr, data);
      end
      repeat (8) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (8) @(negedge clk);
    sload_n = 1'b1;
    repeat (3) @(posedge clk);
    e_oe = 0;
    repeat (8) @(negedge clk);
    in_wr_frame = 0;
  endtask

  task automatic wr(int addr, int data);
    int dummy;
    xfer(1'b0, addr, data, 14, dummy);
  endtask

  task automatic rd_check(string tag, int addr, int exp);
    int got;
    xfer(1'b1, addr, 0, 14, got);
    check(tag, got, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1..all actual=timeout expected=completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    int tmp;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 reset awake", int'(cfg_awake), 1);
    check("R1 reset other config", int'({cfg_ext_ref, cfg_single_byte, cfg_sha_mode, cfg_range_hi, cfg_slow}), 0);
    check("R1 reset gains", int'(gain_codes), 0);
    check("R1 reset offsets", int'(offset_twos != 0), 0);
    check("R1 reset enable", int'(sdio_oe), 0);
    run_cmp = 1;
    rd_check("R1 reset config read", 0, 1);

    // R4 reserved config bits dropped
    wr(0, 'h1FF);
    rd_check("R4 config readback reserved zero", 0, 'h03F);
    wr(0, 'h0AA);
    rd_check("R4 config readback", 0, 'h02A);

    // R5 sequencing register
    wr(1, 'h1F3);
    rd_check("R5 sequencing readback", 1, 'h013);
    check("R5 channel A select bit", int'(mux_sel[3]), 0);

    // R3 R6 R7 map of all ten registers
    wr(2, 'h1FF);
    wr(3, 'h015);
    wr(4, 'h02A);
    wr(5, 'h0C1);
    wr(6, 'h0FF);
    wr(7, 'h1FF);
    wr(8, 'h100);
    wr(9, 'h105);
    rd_check("R6 gain A reserved zero", 2, 'h03F);
    rd_check("R3 gain B", 3, 'h015);
    rd_check("R3 gain C", 4, 'h02A);
    rd_check("R6 gain D", 5, 'h001);
    rd_check("R7 offset A raw", 6, 'h0FF);
    rd_check("R7 offset B raw", 7, 'h1FF);
    rd_check("R7 offset C negative zero raw", 8, 'h100);
    rd_check("R3 offset D", 9, 'h105);
    check("R7 offset C exports zero", int'(offset_twos[18 +: 9]), 0);
    check("R7 offset D exports -5", int'(offset_twos[27 +: 9]), 'h1FB);

    // R8 unused addresses
    wr(10, 'h1FF);
    wr(15, 'h155);
    rd_check("R8 unused read zero", 12, 0);
    rd_check("R8 unused write left gain A", 2, 'h03F);
    rd_check("R8 unused write left config", 0, 'h02A);

    // R11 short and long frames
    begin
      xfer(1'b0, 3, 'h033, 10, tmp);
      rd_check("R11 aborted frame no write", 3, 'h015);
      xfer(1'b0, 3, 'h02A, 16, tmp);
      rd_check("R11 extra bits ignored", 3, 'h02A);
    end

    // R12 power-down retains contents
    wr(0, 'h03E);
    check("R12 power-down field", int'(cfg_awake), 0);
    rd_check("R12 gain A kept", 2, 'h03F);
    rd_check("R12 offset B kept", 7, 'h1FF);
    rd_check("R12 sequencing kept", 1, 'h013);
    wr(0, 'h001);
    rd_check("R12 wake config", 0, 'h001);

    // R2 R10 a write frame never drove the line
    check("R10 no enable during writes", int'(oe_seen_wr), 0);
    wr(6, 'h080);
    check("R2 offset A written via frame", int'(offset_twos[0 +: 9]), 'h080);

    repeat (10) @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule